// File: doc/BRIEF.md
# UART Register Front End with AXI4-Lite Access

This block sits between an AXI4-Lite bus and the byte queues of a serial port. Four 32-bit word locations are decoded. A read of the receive location removes one byte from the receive queue. A write to the transmit location offers one byte to the transmit queue. The other two locations are a read-only status word and a small read/write control word. A single interrupt line combines the conditions that software has enabled.

The queues are outside the block. The receive side presents a byte with a valid flag and takes a one-cycle `rx_ready` pop strobe. The transmit side takes a one-cycle `tx_valid` push strobe, and the byte is accepted only when `tx_ready` is high. The queues also supply level flags for full, empty and overrun. Reset is synchronous and active high. Protection attributes and byte strobes have no effect.

Top module: `uart_axil_regs`

## Requirements
- R1: After reset, `s_bvalid`, `s_rvalid` and `irq` are low, the control word reads 0, and both sticky status bits read 0.
- R2: A read of word offset 0x0 while `rx_valid` is high returns `rx_data` zero-extended to 32 bits. It raises `rx_ready` for exactly one cycle, so exactly one byte is popped.
- R3: A read of offset 0x0 while `rx_valid` is low returns 0 and never raises `rx_ready`.
- R4: A write to offset 0x4 produces one `tx_valid` strobe carrying `wdata[7:0]`, and that byte is transferred when `tx_ready` is high. A read of offset 0x4 returns 0.
- R5: A write to offset 0x4 while `tx_ready` is low transfers no byte and sets status bit 5 (transmit overflow).
- R6: Status word at offset 0x8: bit 0 = `rx_valid`, bit 1 = `rx_full`, bit 2 = not `tx_ready` (transmit queue full), bit 3 = `tx_empty`, bits 4 and 5 are sticky, and all other bits are 0.
- R7: Sticky status bits 4 and 5 stay set until a status read. That read still returns them set and clears them afterwards. A new event in the same cycle as the read wins over the clear.
- R8: Control word at offset 0xC: bits 1:0 are writable and read back, and all other bits read 0.
- R9: `irq` = (control bit 0 AND `rx_valid`) OR (control bit 1 AND `tx_empty`).
- R10: Write address and write data may arrive in either order or together. The write response appears only after both have been accepted, carries OKAY (2'b00), and each address/data pair produces exactly one register write.
- R11: Accesses to offsets 0x10 and above complete with OKAY. Reads return 0, and writes change no state and push nothing.
- R12: `s_rvalid` and `s_bvalid` stay high until accepted, and `s_rdata` stays stable while `s_rvalid` waits.
- R13: A one-cycle pulse on `rx_overrun` sets sticky status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| tx_data | output | 8 | Byte offered to transmit queue |
| tx_valid | output | 1 | Push strobe to transmit queue |
| tx_ready | input | 1 | Transmit queue can take a byte |
| tx_empty | input | 1 | Transmit queue is empty |
| rx_data | input | 8 | Head byte of receive queue |
| rx_valid | input | 1 | Receive queue holds a byte |
| rx_ready | output | 1 | Pop strobe to receive queue |
| rx_full | input | 1 | Receive queue is full |
| rx_overrun | input | 1 | Pulse: a received byte was lost |
| irq | output | 1 | Interrupt request |

## Verification
The bench reads the receive location while the queue is empty. A design that pops anyway would skip a byte, and one that returns stale data would show a nonzero word. It stalls the transmit queue and writes to it. A wrong design would push the byte or fail to set the overflow bit. It then reads status twice, which catches sticky bits that clear too early, before the first read reports them, or not at all. Writes are sent with address first, with data first, and with both together, and the bench watches for a response that comes before both halves are accepted. Finally it holds off the read-data acceptance, which exposes a response that drops or changes its data while waiting.

// File: rtl/uart_axil_pkg.sv
package uart_axil_pkg;

    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int CTRL_BITS = 2;

    localparam int ST_RX_AVAIL = 0;
    localparam int ST_RX_FULL  = 1;
    localparam int ST_TX_FULL  = 2;
    localparam int ST_TX_EMPTY = 3;
    localparam int ST_RX_OVR   = 4;
    localparam int ST_TX_OVF   = 5;
    localparam int ST_BITS     = 6;

    localparam int CTL_RX_IE = 0;
    localparam int CTL_TX_IE = 1;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [2:0] {
        SEL_RX,
        SEL_TX,
        SEL_STAT,
        SEL_CTRL,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic               fire;
        reg_sel_e           sel;
        logic [DATA_W-1:0]  data;
    } wr_req_t;

    // Word index (byte address >> 2) to register select.
    function automatic reg_sel_e decode_word(input logic [29:0] widx);
        reg_sel_e s;
        if (widx[29:2] != '0) begin
            s = SEL_NONE;
        end else begin
            case (widx[1:0])
                2'd0:    s = SEL_RX;
                2'd1:    s = SEL_TX;
                2'd2:    s = SEL_STAT;
                default: s = SEL_CTRL;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/uart_axil_wr.sv
module uart_axil_wr
    import uart_axil_pkg::*;
#(
    parameter int WIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDX_W-1:0] awidx,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output wr_req_t           req
);

    logic              aw_held, w_held, bvalid_q;
    logic [WIDX_W-1:0] idx_q;
    logic [DATA_W-1:0] data_q;
    logic              fire;

    assign awready = !aw_held && !bvalid_q;
    assign wready  = !w_held  && !bvalid_q;
    assign fire    = aw_held && w_held;
    assign bvalid  = bvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_held  <= 1'b0;
            w_held   <= 1'b0;
            bvalid_q <= 1'b0;
            idx_q    <= '0;
            data_q   <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_held <= 1'b1;
                idx_q   <= awidx;
            end
            if (wvalid && wready) begin
                w_held <= 1'b1;
                data_q <= wdata;
            end
            if (fire) begin
                aw_held  <= 1'b0;
                w_held   <= 1'b0;
                bvalid_q <= 1'b1;
            end else if (bvalid_q && bready) begin
                bvalid_q <= 1'b0;
            end
        end
    end

    always_comb begin
        req.fire = fire;
        req.sel  = decode_word(30'(idx_q));
        req.data = data_q;
    end

    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid); // R12

    AST_FIRE_GIVES_RESP: assert property (@(posedge clk) disable iff (rst)
        fire |=> (bvalid && !fire)); // R10

endmodule

// File: rtl/uart_axil_rd.sv
module uart_axil_rd
    import uart_axil_pkg::*;
#(
    parameter int WIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDX_W-1:0] aridx,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    output logic              rd_fire,
    output reg_sel_e          rd_sel,
    input  logic [DATA_W-1:0] rd_value
);

    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    assign arready = !rvalid_q;
    assign rd_fire = arvalid && arready;
    assign rd_sel  = decode_word(30'(aridx));
    assign rvalid  = rvalid_q;
    assign rdata   = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_value;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

    AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R12

    AST_R_NEEDS_AR: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> $past(arvalid)); // R2

endmodule

// File: rtl/uart_csr.sv
module uart_csr
    import uart_axil_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic              rd_fire,
    input  reg_sel_e          rd_sel,
    output logic [DATA_W-1:0] rd_value,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_full,
    input  logic              rx_overrun,
    output logic              irq
);

    logic [CTRL_BITS-1:0] ctrl_q;
    logic                 ovr_q, txovf_q;
    logic [ST_BITS-1:0]   status;
    logic                 stat_rd;

    assign tx_valid = wr.fire && (wr.sel == SEL_TX);
    assign tx_data  = wr.data[BYTE_W-1:0];
    assign rx_ready = rd_fire && (rd_sel == SEL_RX) && rx_valid;
    assign stat_rd  = rd_fire && (rd_sel == SEL_STAT);

    always_comb begin
        status              = '0;
        status[ST_RX_AVAIL] = rx_valid;
        status[ST_RX_FULL]  = rx_full;
        status[ST_TX_FULL]  = !tx_ready;
        status[ST_TX_EMPTY] = tx_empty;
        status[ST_RX_OVR]   = ovr_q;
        status[ST_TX_OVF]   = txovf_q;
    end

    always_comb begin
        rd_value = '0;
        case (rd_sel)
            SEL_RX:   if (rx_valid) rd_value = DATA_W'(rx_data);
            SEL_STAT: rd_value = DATA_W'(status);
            SEL_CTRL: rd_value = DATA_W'(ctrl_q);
            default:  rd_value = '0;
        endcase
    end

    assign irq = (ctrl_q[CTL_RX_IE] && rx_valid) || (ctrl_q[CTL_TX_IE] && tx_empty);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ovr_q   <= 1'b0;
            txovf_q <= 1'b0;
        end else begin
            if (wr.fire && wr.sel == SEL_CTRL) begin
                ctrl_q <= wr.data[CTRL_BITS-1:0];
            end
            if (stat_rd) begin
                ovr_q   <= 1'b0;
                txovf_q <= 1'b0;
            end
            if (rx_overrun) begin
                ovr_q <= 1'b1;
            end
            if (tx_valid && !tx_ready) begin
                txovf_q <= 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> txovf_q); // R5

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (txovf_q && !stat_rd) |=> txovf_q); // R7

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> ovr_q); // R13

    AST_POP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> !rx_ready); // R2

endmodule

// File: rtl/uart_axil_regs.sv
module uart_axil_regs
    import uart_axil_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              tx_empty,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_full,
    input  logic              rx_overrun,
    output logic              irq
);

    localparam int WIDX_W = ADDR_W - 2;

    wr_req_t           wr_req;
    logic              rd_fire;
    reg_sel_e          rd_sel;
    logic [DATA_W-1:0] rd_value;

    logic unused_bits;
    assign unused_bits = ^{s_wstrb, s_awaddr[1:0], s_araddr[1:0]};

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    uart_axil_wr #(.WIDX_W(WIDX_W)) wr_i (
        .clk     (clk),
        .rst     (rst),
        .awidx   (s_awaddr[ADDR_W-1:2]),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .req     (wr_req)
    );

    uart_axil_rd #(.WIDX_W(WIDX_W)) rd_i (
        .clk      (clk),
        .rst      (rst),
        .aridx    (s_araddr[ADDR_W-1:2]),
        .arvalid  (s_arvalid),
        .arready  (s_arready),
        .rdata    (s_rdata),
        .rvalid   (s_rvalid),
        .rready   (s_rready),
        .rd_fire  (rd_fire),
        .rd_sel   (rd_sel),
        .rd_value (rd_value)
    );

    uart_csr csr_i (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_req),
        .rd_fire    (rd_fire),
        .rd_sel     (rd_sel),
        .rd_value   (rd_value),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_empty   (tx_empty),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_full    (rx_full),
        .rx_overrun (rx_overrun),
        .irq        (irq)
    );

endmodule

// File: tb/uart_axil_regs_tb_top.sv
module uart_axil_regs_tb_top;

    logic clk = 1'b0;
    logic rst;
    always #2 clk = ~clk;

    logic [7:0]  s_awaddr, s_araddr;
    logic        s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
    logic [31:0] s_wdata, s_rdata;
    logic [3:0]  s_wstrb;
    logic [1:0]  s_bresp, s_rresp;
    logic        s_arvalid, s_arready, s_rvalid, s_rready;
    logic [7:0]  tx_data, rx_data;
    logic        tx_valid, tx_ready, tx_empty, rx_valid, rx_ready, rx_full, rx_overrun, irq;

    int checks = 0;
    int fails  = 0;

    // receive queue model
    logic [7:0] rx_mem [16];
    int rx_wr = 0;
    int rx_rd = 0;
    assign rx_valid = (rx_wr != rx_rd);
    assign rx_data  = rx_mem[rx_rd % 16];

    // scoreboards
    logic [31:0] rd_q [$];
    string       rd_tag [$];
    logic [7:0]  tx_q [$];
    int          tx_cnt = 0;

    uart_axil_regs dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        if (!rst && rx_ready) rx_rd <= rx_rd + 1;
    end

    // read-data monitor
    always @(posedge clk) begin
        if (!rst && s_rvalid && s_rready) begin
            if (rd_q.size() == 0) begin
                check("R12 unexpected read response", s_rdata, 32'hDEAD_BEEF);
            end else begin
                check(rd_tag.pop_front(), s_rdata, rd_q.pop_front());
                check("R10 rresp OKAY", {30'd0, s_rresp}, 32'd0);
            end
        end
    end

    // transmit monitor
    always @(posedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            tx_cnt++;
            if (tx_q.size() == 0)
                check("R5 unexpected tx byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
            else
                check("R4 tx byte", {24'd0, tx_data}, {24'd0, tx_q.pop_front()});
        end
    end

    task automatic rx_put(input logic [7:0] b);
        rx_mem[rx_wr % 16] = b;
        rx_wr++;
    endtask

    task automatic axi_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        logic ok;
        rd_q.push_back(e);
        rd_tag.push_back(tag);
        s_araddr  = a;
        s_arvalid = 1'b1;
        do begin
            ok = s_arready;
            @(negedge clk);
        end while (!ok);
        s_arvalid = 1'b0;
        while (rd_q.size() != 0) @(negedge clk);
    endtask

    // order: 0 together, 1 address first, 2 data first
    task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input int order);
        logic aw_sent, w_sent, aw_hs, w_hs;
        int cyc;
        aw_sent = 1'b0; w_sent = 1'b0; cyc = 0;
        s_awaddr = a;
        s_wdata  = d;
        s_awvalid = (order != 2);
        s_wvalid  = (order != 1);
        while (!(aw_sent && w_sent)) begin
            aw_hs = s_awvalid && s_awready;
            w_hs  = s_wvalid && s_wready;
            if (s_bvalid) check("R10 response before both halves", 32'd1, 32'd0);
            @(negedge clk);
            cyc++;
            if (aw_hs) begin s_awvalid = 1'b0; aw_sent = 1'b1; end
            if (w_hs)  begin s_wvalid  = 1'b0; w_sent  = 1'b1; end
            if (order == 1 && aw_sent && !w_sent && cyc >= 3) s_wvalid = 1'b1;
            if (order == 2 && w_sent && !aw_sent && cyc >= 3) s_awvalid = 1'b1;
        end
        while (!s_bvalid) @(negedge clk);
        check("R10 bresp OKAY", {30'd0, s_bresp}, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int pops, txc;
        rst = 1'b1;
        s_awaddr = '0; s_awvalid = 0; s_wdata = '0; s_wstrb = 4'hF; s_wvalid = 0;
        s_bready = 1; s_araddr = '0; s_arvalid = 0; s_rready = 1;
        tx_ready = 1; tx_empty = 1; rx_full = 0; rx_overrun = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 bvalid", {31'd0, s_bvalid}, 0);
        check("R1 rvalid", {31'd0, s_rvalid}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        axi_read(8'h0C, 32'h0, "R1 control after reset");
        axi_read(8'h08, 32'h08, "R1 R6 status after reset");

        // R3 empty receive read
        pops = rx_rd;
        axi_read(8'h00, 32'h0, "R3 empty rx read");
        check("R3 no pop", rx_rd, pops);

        // R2 receive reads
        rx_put(8'hA5); rx_put(8'h3C);
        axi_read(8'h00, 32'hA5, "R2 rx first byte");
        check("R2 one pop", rx_rd, pops + 1);
        axi_read(8'h00, 32'h3C, "R2 rx second byte");
        check("R2 second pop", rx_rd, pops + 2);

        // R6 status layout
        rx_put(8'h11); rx_full = 1; tx_ready = 0; tx_empty = 0;
        @(negedge clk);
        axi_read(8'h08, 32'h07, "R6 status busy pattern");
        tx_ready = 1; rx_full = 0;
        axi_read(8'h00, 32'h11, "R2 drain");

        // R4 / R10 transmit writes in all orders
        tx_q.push_back(8'hC3); axi_write(8'h04, 32'h1234_56C3, 0);
        tx_q.push_back(8'h5A); axi_write(8'h04, 32'h0000_005A, 1);
        tx_q.push_back(8'h7E); axi_write(8'h04, 32'hFFFF_FF7E, 2);
        check("R4 tx count", tx_cnt, 3);
        axi_read(8'h04, 32'h0, "R4 tx offset reads zero");

        // R5 / R7 overflow
        tx_ready = 0;
        txc = tx_cnt;
        axi_write(8'h04, 32'h99, 0);
        check("R5 dropped byte", tx_cnt, txc);
        axi_read(8'h08, 32'h24, "R5 R7 overflow flagged");
        tx_ready = 1;
        axi_read(8'h08, 32'h00, "R7 sticky cleared by read");
        tx_empty = 1;

        // R13 overrun
        rx_overrun = 1; @(negedge clk); rx_overrun = 0; @(negedge clk);
        axi_read(8'h08, 32'h18, "R13 overrun flagged");
        axi_read(8'h08, 32'h08, "R7 overrun cleared");

        // R8 control
        axi_write(8'h0C, 32'hFFFF_FFFF, 0);
        axi_read(8'h0C, 32'h3, "R8 control readback");

        // R9 interrupt
        @(negedge clk);
        check("R9 irq tx empty enabled", {31'd0, irq}, 1);
        tx_empty = 0; @(negedge clk);
        check("R9 irq no condition", {31'd0, irq}, 0);
        rx_put(8'h42); @(negedge clk);
        check("R9 irq rx avail", {31'd0, irq}, 1);
        axi_write(8'h0C, 32'h2, 1);
        check("R9 irq rx disabled", {31'd0, irq}, 0);
        tx_empty = 1; @(negedge clk);
        check("R9 irq tx only", {31'd0, irq}, 1);
        axi_write(8'h0C, 32'h0, 2);
        check("R9 irq all disabled", {31'd0, irq}, 0);
        axi_read(8'h00, 32'h42, "R2 drain irq byte");

        // R11 unmapped
        txc = tx_cnt;
        axi_write(8'h20, 32'hFF, 0);
        axi_write(8'h14, 32'hFF, 1);
        axi_read(8'h0C, 32'h0, "R11 control untouched");
        axi_read(8'h20, 32'h0, "R11 unmapped read zero");
        check("R11 no push", tx_cnt, txc);

        // R12 read response held while not accepted
        axi_write(8'h0C, 32'h1, 0);
        s_rready = 0;
        rd_q.push_back(32'h1); rd_tag.push_back("R12 held read data");
        s_araddr = 8'h0C; s_arvalid = 1;
        @(negedge clk);
        s_arvalid = 0;
        repeat (3) @(negedge clk);
        check("R12 rvalid held", {31'd0, s_rvalid}, 1);
        check("R12 rdata held", s_rdata, 32'h1);
        s_rready = 1;
        while (rd_q.size() != 0) @(negedge clk);

        check("R4 all tx bytes seen", tx_q.size(), 0);
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule